// File: doc/BRIEF.md
# Exception Pend and Escalation Controller

This block keeps the pending and active state of a parameterised set of numbered exceptions. Each vector has a priority, an enable and, when it is banked, a second secure copy of its pending and active bits. A pend request carries a vector number, a secure flag and a derived flag. A derived request is one raised while the core is already part way into taking another exception. The block turns synchronous faults that cannot be taken into a hard fault. It raises a sticky lockup when a derived hard fault cannot beat the exception being taken. It also rejects a derived debug-monitor fault whose priority is too low.

Every cycle, combinational logic picks the most urgent pending, enabled vector. It reports that vector's number, bank, priority and secure-target flag. A one-cycle preempt pulse tells the core that a newly pended vector beats the current choice. An acknowledge from the core moves the chosen vector from pending to active. Configuration (enables, priorities, target-secure bits) arrives on plain input ports, and the running execution priority is an input.

Top module: `exc_pend_ctrl`

## Requirements
- R1: After reset all pending and active bits are zero, lockup and preempt are low, and the selection reports no vector (valid low) with the idle priority 2**PRIO_W.
- R2: A non-derived request for vector n sets pending bit n in the secure bank when the secure flag is set and n is banked, and in the shared (non-secure) bank otherwise.
- R3: A request for a synchronous vector 4..13 that is disabled, or whose priority value is not strictly below the execution priority, pends hard fault (vector 3) instead. The hard fault goes to the secure bank when the secure flag is set, because vector 3 is banked. Vectors outside 3..13 never escalate.
- R4: A derived request for the debug-monitor vector 12 whose priority value is at or above the execution priority changes no state.
- R5: A derived request for hard fault whose priority value is at or above the selected pending priority sets lockup and pends nothing. Lockup then stays high until reset.
- R6: A derived request for a vector outside 3..13 changes no state. A derived request that is neither dropped nor locked follows the normal path of R2 and R3.
- R7: The selection is the pending vector with the lowest priority value among enabled vectors, with hard fault always counted as enabled. Ties go to the lowest vector number, and at equal number to the shared bank.
- R8: preempt is high for one cycle, one cycle after a request that pends an enabled vector with a priority value strictly below the selected priority at request time.
- R9: On acknowledge, the selected vector's active bit in its bank is set and its pending bit is cleared at the next edge.
- R10: The secure-target flag is high when the selection comes from the secure bank. Otherwise it is high only when the selected vector is not banked and its target-secure bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | NVEC | Per-vector enable |
| tgt_secure_i | input | NVEC | Per-vector target-secure configuration |
| prio_ns_i | input | NVEC*PRIO_W | Shared-bank priority, vector k at bits k*PRIO_W |
| prio_s_i | input | NVEC*PRIO_W | Secure-bank priority, same layout |
| exec_prio_i | input | PRIO_W+1 | Current execution priority (2**PRIO_W = none running) |
| req_valid_i | input | 1 | Pend request strobe |
| req_num_i | input | NUM_W | Requested vector number |
| req_secure_i | input | 1 | Request targets the secure bank |
| req_derived_i | input | 1 | Request is a derived exception |
| ack_i | input | 1 | Core takes the selected vector |
| pend_ns_o | output | NVEC | Shared-bank pending bits |
| pend_s_o | output | NVEC | Secure-bank pending bits |
| act_ns_o | output | NVEC | Shared-bank active bits |
| act_s_o | output | NVEC | Secure-bank active bits |
| sel_valid_o | output | 1 | A vector is selected |
| sel_num_o | output | NUM_W | Selected vector number |
| sel_secure_o | output | 1 | Selection comes from the secure bank |
| sel_prio_o | output | PRIO_W+1 | Selected priority, idle value when none |
| sel_tgt_secure_o | output | 1 | Secure-target flag of the selection |
| preempt_o | output | 1 | Pulse: new pend beats the selection |
| lockup_o | output | 1 | Sticky lockup |

## Verification
Pending, active, lockup and preempt are registered, so a request or acknowledge driven before an edge shows its effect on those outputs right after that one edge. The selection outputs are combinational over the registered pending bits, so they follow in the same interval. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. The preempt pulse is therefore caught in its only high cycle, and its absence is checked in that same cycle. Stickiness of lockup is checked one further idle cycle later.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
    // Fixed architectural vector numbers
    localparam int EXC_HARD   = 3;
    localparam int EXC_DEBUG  = 12;
    localparam int EXC_PENDSV = 14;

    function automatic logic is_sync(input int n);
        return (n >= EXC_HARD) && (n < EXC_PENDSV);
    endfunction
endpackage

// File: rtl/exc_prio_select.sv
module exc_prio_select
    import exc_pend_pkg::*;
#(
    parameter int NVEC   = 32,
    parameter int PRIO_W = 3,
    localparam int NUM_W = $clog2(NVEC)
) (
    input  logic [NVEC-1:0]        pend_ns_i,
    input  logic [NVEC-1:0]        pend_s_i,
    input  logic [NVEC-1:0]        en_i,
    input  logic [NVEC*PRIO_W-1:0] prio_ns_i,
    input  logic [NVEC*PRIO_W-1:0] prio_s_i,
    output logic                   valid_o,
    output logic [NUM_W-1:0]       num_o,
    output logic                   secure_o,
    output logic [PRIO_W:0]        prio_o
);
    localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(1 << PRIO_W);

    always_comb begin
        valid_o  = 1'b0;
        num_o    = '0;
        secure_o = 1'b0;
        prio_o   = IDLE;
        // Ascending scan with strict compare: lowest number, shared bank first
        for (int k = 0; k < NVEC; k++) begin
            if (pend_ns_i[k] && (en_i[k] || k == EXC_HARD) &&
                ({1'b0, prio_ns_i[k*PRIO_W +: PRIO_W]} < prio_o)) begin
                valid_o  = 1'b1;
                num_o    = NUM_W'(k);
                secure_o = 1'b0;
                prio_o   = {1'b0, prio_ns_i[k*PRIO_W +: PRIO_W]};
            end
            if (pend_s_i[k] && (en_i[k] || k == EXC_HARD) &&
                ({1'b0, prio_s_i[k*PRIO_W +: PRIO_W]} < prio_o)) begin
                valid_o  = 1'b1;
                num_o    = NUM_W'(k);
                secure_o = 1'b1;
                prio_o   = {1'b0, prio_s_i[k*PRIO_W +: PRIO_W]};
            end
        end
    end
endmodule

// File: rtl/exc_req_decode.sv
module exc_req_decode
    import exc_pend_pkg::*;
#(
    parameter int              NVEC   = 32,
    parameter int              PRIO_W = 3,
    parameter logic [NVEC-1:0] BANKED = NVEC'(32'h0000_C858),
    localparam int             NUM_W  = $clog2(NVEC)
) (
    input  logic                   req_valid_i,
    input  logic [NUM_W-1:0]       req_num_i,
    input  logic                   req_secure_i,
    input  logic                   req_derived_i,
    input  logic [NVEC-1:0]        en_i,
    input  logic [NVEC*PRIO_W-1:0] prio_ns_i,
    input  logic [NVEC*PRIO_W-1:0] prio_s_i,
    input  logic [PRIO_W:0]        exec_prio_i,
    input  logic [PRIO_W:0]        sel_prio_i,
    output logic                   do_pend_o,
    output logic [NUM_W-1:0]       pend_num_o,
    output logic                   pend_bank_s_o,
    output logic                   pend_en_o,
    output logic [PRIO_W:0]        pend_prio_o,
    output logic                   set_lock_o
);
    int              n;
    logic            bank_s, hard_s, sync;
    logic [PRIO_W:0] rq_prio, hard_prio;

    always_comb begin
        n         = int'(req_num_i);
        bank_s    = req_secure_i && BANKED[req_num_i];
        hard_s    = req_secure_i && BANKED[EXC_HARD];
        rq_prio   = bank_s ? {1'b0, prio_s_i[n*PRIO_W +: PRIO_W]}
                           : {1'b0, prio_ns_i[n*PRIO_W +: PRIO_W]};
        hard_prio = hard_s ? {1'b0, prio_s_i[EXC_HARD*PRIO_W +: PRIO_W]}
                           : {1'b0, prio_ns_i[EXC_HARD*PRIO_W +: PRIO_W]};
        sync      = is_sync(n);

        do_pend_o     = 1'b0;
        pend_num_o    = req_num_i;
        pend_bank_s_o = bank_s;
        pend_prio_o   = rq_prio;
        set_lock_o    = 1'b0;

        if (req_valid_i && n < NVEC) begin
            if (req_derived_i && !sync) begin
                // illegal derived number: dropped
            end else if (req_derived_i && n == EXC_DEBUG && rq_prio >= exec_prio_i) begin
                // low-priority derived debug fault: dropped
            end else if (req_derived_i && n == EXC_HARD && rq_prio >= sel_prio_i) begin
                set_lock_o = 1'b1;
            end else if (sync && n != EXC_HARD && (!en_i[req_num_i] || rq_prio >= exec_prio_i)) begin
                do_pend_o     = 1'b1;
                pend_num_o    = NUM_W'(EXC_HARD);
                pend_bank_s_o = hard_s;
                pend_prio_o   = hard_prio;
            end else begin
                do_pend_o = 1'b1;
            end
        end
        pend_en_o = en_i[pend_num_o] || (int'(pend_num_o) == EXC_HARD);
    end
endmodule

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl
    import exc_pend_pkg::*;
#(
    parameter int              NVEC   = 32,
    parameter int              PRIO_W = 3,
    parameter logic [NVEC-1:0] BANKED = NVEC'(32'h0000_C858),
    localparam int             NUM_W  = $clog2(NVEC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NVEC-1:0]        en_i,
    input  logic [NVEC-1:0]        tgt_secure_i,
    input  logic [NVEC*PRIO_W-1:0] prio_ns_i,
    input  logic [NVEC*PRIO_W-1:0] prio_s_i,
    input  logic [PRIO_W:0]        exec_prio_i,
    input  logic                   req_valid_i,
    input  logic [NUM_W-1:0]       req_num_i,
    input  logic                   req_secure_i,
    input  logic                   req_derived_i,
    input  logic                   ack_i,
    output logic [NVEC-1:0]        pend_ns_o,
    output logic [NVEC-1:0]        pend_s_o,
    output logic [NVEC-1:0]        act_ns_o,
    output logic [NVEC-1:0]        act_s_o,
    output logic                   sel_valid_o,
    output logic [NUM_W-1:0]       sel_num_o,
    output logic                   sel_secure_o,
    output logic [PRIO_W:0]        sel_prio_o,
    output logic                   sel_tgt_secure_o,
    output logic                   preempt_o,
    output logic                   lockup_o
);
    typedef struct packed {
        logic [NVEC-1:0] pend_ns;
        logic [NVEC-1:0] pend_s;
        logic [NVEC-1:0] act_ns;
        logic [NVEC-1:0] act_s;
        logic            preempt;
        logic            lockup;
    } state_t;

    state_t s_d, s_q;

    logic            do_pend, pend_bank_s, pend_en, set_lock;
    logic [NUM_W-1:0] pend_num;
    logic [PRIO_W:0] pend_prio;

    exc_prio_select #(.NVEC(NVEC), .PRIO_W(PRIO_W)) u_sel (
        .pend_ns_i (s_q.pend_ns),
        .pend_s_i  (s_q.pend_s),
        .en_i      (en_i),
        .prio_ns_i (prio_ns_i),
        .prio_s_i  (prio_s_i),
        .valid_o   (sel_valid_o),
        .num_o     (sel_num_o),
        .secure_o  (sel_secure_o),
        .prio_o    (sel_prio_o)
    );

    exc_req_decode #(.NVEC(NVEC), .PRIO_W(PRIO_W), .BANKED(BANKED)) u_dec (
        .req_valid_i   (req_valid_i),
        .req_num_i     (req_num_i),
        .req_secure_i  (req_secure_i),
        .req_derived_i (req_derived_i),
        .en_i          (en_i),
        .prio_ns_i     (prio_ns_i),
        .prio_s_i      (prio_s_i),
        .exec_prio_i   (exec_prio_i),
        .sel_prio_i    (sel_prio_o),
        .do_pend_o     (do_pend),
        .pend_num_o    (pend_num),
        .pend_bank_s_o (pend_bank_s),
        .pend_en_o     (pend_en),
        .pend_prio_o   (pend_prio),
        .set_lock_o    (set_lock)
    );

    always_comb begin
        s_d         = s_q;
        s_d.preempt = 1'b0;
        // Acknowledge first, so a same-cycle pend of that vector survives
        if (ack_i && sel_valid_o) begin
            if (sel_secure_o) begin
                s_d.pend_s[sel_num_o] = 1'b0;
                s_d.act_s[sel_num_o]  = 1'b1;
            end else begin
                s_d.pend_ns[sel_num_o] = 1'b0;
                s_d.act_ns[sel_num_o]  = 1'b1;
            end
        end
        if (do_pend) begin
            if (pend_bank_s) s_d.pend_s[pend_num]  = 1'b1;
            else             s_d.pend_ns[pend_num] = 1'b1;
            s_d.preempt = pend_en && (pend_prio < sel_prio_o);
        end
        if (set_lock) s_d.lockup = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_ns_o        = s_q.pend_ns;
    assign pend_s_o         = s_q.pend_s;
    assign act_ns_o         = s_q.act_ns;
    assign act_s_o          = s_q.act_s;
    assign preempt_o        = s_q.preempt;
    assign lockup_o         = s_q.lockup;
    assign sel_tgt_secure_o = sel_valid_o &&
                              (sel_secure_o || (!BANKED[sel_num_o] && tgt_secure_i[sel_num_o]));
endmodule

// File: rtl/exc_pend_ctrl_chk.sv
module exc_pend_ctrl_chk #(
    parameter int  NVEC   = 32,
    parameter int  PRIO_W = 3,
    localparam int NUM_W  = $clog2(NVEC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PRIO_W:0]  exec_prio_i,
    input logic             req_valid_i,
    input logic             ack_i,
    input logic [NVEC-1:0]  pend_ns_o,
    input logic [NVEC-1:0]  pend_s_o,
    input logic [NVEC-1:0]  act_ns_o,
    input logic [NVEC-1:0]  act_s_o,
    input logic             sel_valid_o,
    input logic [NUM_W-1:0] sel_num_o,
    input logic             sel_secure_o,
    input logic [PRIO_W:0]  sel_prio_o,
    input logic             preempt_o,
    input logic             lockup_o
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lockup_o |=> lockup_o); // R5

    AST_PREEMPT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> $past(req_valid_i)); // R8

    AST_ACK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> (sel_valid_o && sel_prio_o < exec_prio_i)); // R9

    AST_ACK_NS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && sel_valid_o && !sel_secure_o) |=> act_ns_o[$past(sel_num_o)]); // R9

    AST_ACK_S_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && sel_valid_o && sel_secure_o) |=> act_s_o[$past(sel_num_o)]); // R9

    AST_SEL_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (sel_secure_o ? pend_s_o[sel_num_o] : pend_ns_o[sel_num_o])); // R7
endmodule

bind exc_pend_ctrl exc_pend_ctrl_chk #(.NVEC(NVEC), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/exc_pend_ctrl_test.sv
`timescale 1ns/1ps
module exc_pend_ctrl_test;
    localparam int NVEC = 32, PRIO_W = 3, NUM_W = 5;

    logic clk = 0, rst_n = 0;
    logic [NVEC-1:0] en, tgt;
    logic [NVEC*PRIO_W-1:0] prio_ns, prio_s;
    logic [PRIO_W:0] exec_prio;
    logic req_valid, req_secure, req_derived, ack;
    logic [NUM_W-1:0] req_num;
    logic [NVEC-1:0] pend_ns, pend_s, act_ns, act_s;
    logic sel_valid, sel_secure, sel_tgt, preempt, lockup;
    logic [NUM_W-1:0] sel_num;
    logic [PRIO_W:0] sel_prio;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    exc_pend_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .tgt_secure_i(tgt),
        .prio_ns_i(prio_ns), .prio_s_i(prio_s), .exec_prio_i(exec_prio),
        .req_valid_i(req_valid), .req_num_i(req_num), .req_secure_i(req_secure),
        .req_derived_i(req_derived), .ack_i(ack),
        .pend_ns_o(pend_ns), .pend_s_o(pend_s), .act_ns_o(act_ns), .act_s_o(act_s),
        .sel_valid_o(sel_valid), .sel_num_o(sel_num), .sel_secure_o(sel_secure),
        .sel_prio_o(sel_prio), .sel_tgt_secure_o(sel_tgt),
        .preempt_o(preempt), .lockup_o(lockup)
    );

    typedef struct packed {
        logic [3:0]  ex;
        logic [4:0]  num;
        logic        sec;
        logic        der;
        logic [31:0] pns;
        logic [31:0] ps;
        logic        lock;
        logic        pre;
    } row_t;

    // Config: hard 0, v4 2, v5 3 (disabled), v6 5 / secure 1, v12 6, v16 1, v17 6, v20 1, others 4
    localparam int NROW = 14;
    localparam row_t ROWS [NROW] = '{
        '{4'd8, 5'd16, 1'b0, 1'b0, 32'h0001_0000, 32'h0, 1'b0, 1'b1}, // R2 plain pend
        '{4'd8, 5'd5,  1'b0, 1'b0, 32'h0000_0008, 32'h0, 1'b0, 1'b1}, // R3 disabled
        '{4'd2, 5'd4,  1'b0, 1'b0, 32'h0000_0008, 32'h0, 1'b0, 1'b1}, // R3 prio not better
        '{4'd3, 5'd4,  1'b0, 1'b0, 32'h0000_0010, 32'h0, 1'b0, 1'b1}, // R3 no escalation
        '{4'd6, 5'd12, 1'b0, 1'b1, 32'h0,         32'h0, 1'b0, 1'b0}, // R4 dropped
        '{4'd7, 5'd12, 1'b0, 1'b1, 32'h0000_1000, 32'h0, 1'b0, 1'b1}, // R4/R6 kept
        '{4'd8, 5'd3,  1'b0, 1'b1, 32'h0000_0008, 32'h0, 1'b0, 1'b1}, // R5 no lock vs idle
        '{4'd8, 5'd16, 1'b0, 1'b1, 32'h0,         32'h0, 1'b0, 1'b0}, // R6 illegal derived
        '{4'd8, 5'd6,  1'b1, 1'b0, 32'h0, 32'h0000_0040, 1'b0, 1'b1}, // R2 secure bank
        '{4'd8, 5'd16, 1'b1, 1'b0, 32'h0001_0000, 32'h0, 1'b0, 1'b1}, // R2 not banked
        '{4'd8, 5'd18, 1'b0, 1'b0, 32'h0004_0000, 32'h0, 1'b0, 1'b0}, // R8 disabled no pulse
        '{4'd1, 5'd6,  1'b1, 1'b0, 32'h0, 32'h0000_0008, 1'b0, 1'b1}, // R3 secure hard
        '{4'd0, 5'd16, 1'b0, 1'b0, 32'h0001_0000, 32'h0, 1'b0, 1'b1}, // R3 async never
        '{4'd6, 5'd12, 1'b0, 1'b0, 32'h0000_0008, 32'h0, 1'b0, 1'b1}  // R3 debug escalates
    };

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; req_valid = 0; ack = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic pend(input int num, input bit sec, input bit der);
        req_valid = 1; req_num = NUM_W'(num); req_secure = sec; req_derived = der;
        @(negedge clk);
        req_valid = 0; req_derived = 0; req_secure = 0;
    endtask

    task automatic set_prio(input int k, input int p);
        prio_ns[k*PRIO_W +: PRIO_W] = PRIO_W'(p);
        prio_s[k*PRIO_W +: PRIO_W]  = PRIO_W'(p);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        req_valid = 0; req_num = '0; req_secure = 0; req_derived = 0; ack = 0;
        exec_prio = 4'd8;
        en = '1; en[5] = 0; en[18] = 0;
        tgt = '0; tgt[20] = 1; tgt[7] = 1;
        for (int k = 0; k < NVEC; k++) set_prio(k, 4);
        set_prio(3, 0); set_prio(4, 2); set_prio(5, 3); set_prio(6, 5);
        prio_s[6*PRIO_W +: PRIO_W] = 3'd1;
        set_prio(12, 6); set_prio(16, 1); set_prio(17, 6); set_prio(20, 1);

        do_reset();
        check("R1 pend_ns", 64'(pend_ns), 0);
        check("R1 pend_s", 64'(pend_s), 0);
        check("R1 active", 64'({act_ns, act_s}), 0);
        check("R1 lockup/preempt", 64'({lockup, preempt}), 0);
        check("R1 sel_valid", 64'(sel_valid), 0);
        check("R1 sel_prio idle", 64'(sel_prio), 8);

        for (int i = 0; i < NROW; i++) begin
            do_reset();
            exec_prio = ROWS[i].ex;
            pend(int'(ROWS[i].num), ROWS[i].sec, ROWS[i].der);
            check($sformatf("row%0d R2/R3/R4/R6 pend_ns", i), 64'(pend_ns), 64'(ROWS[i].pns));
            check($sformatf("row%0d R2/R3 pend_s", i), 64'(pend_s), 64'(ROWS[i].ps));
            check($sformatf("row%0d R5 lockup", i), 64'(lockup), 64'(ROWS[i].lock));
            check($sformatf("row%0d R8 preempt", i), 64'(preempt), 64'(ROWS[i].pre));
        end

        // R5: derived hard fault cannot beat a pending hard fault -> lockup
        do_reset(); exec_prio = 8;
        pend(3, 0, 0);
        pend(3, 0, 1);
        check("R5 lockup set", 64'(lockup), 1);
        check("R5 nothing new pended", 64'(pend_ns), 64'h8);
        check("R5 no preempt", 64'(preempt), 0);
        @(negedge clk);
        check("R5 lockup sticky", 64'(lockup), 1);

        // R5: derived hard fault that beats the selection pends normally
        do_reset(); exec_prio = 8;
        pend(16, 0, 0);
        pend(3, 0, 1);
        check("R5 no lockup", 64'(lockup), 0);
        check("R5 hard pended", 64'(pend_ns), 64'h0001_0008);
        check("R8 hard preempts", 64'(preempt), 1);

        // R7/R8/R9/R10: tie break, ack, target-secure
        do_reset(); exec_prio = 8;
        pend(20, 0, 0);
        pend(16, 0, 0);
        check("R8 equal prio no pulse", 64'(preempt), 0);
        check("R7 tie lowest number", 64'(sel_num), 16);
        check("R10 tgt of 16", 64'(sel_tgt), 0);
        ack = 1; @(negedge clk); ack = 0;
        check("R9 active 16", 64'(act_ns), 64'h0001_0000);
        check("R9 pending cleared", 64'(pend_ns), 64'h0010_0000);
        check("R7 next selection", 64'(sel_num), 20);
        check("R10 tgt of 20", 64'(sel_tgt), 1);

        // R10: secure-bank selection
        do_reset(); exec_prio = 8;
        pend(6, 1, 0);
        pend(6, 0, 0);
        check("R7 secure bank wins on prio", 64'({sel_num, sel_secure}), 64'({5'd6, 1'b1}));
        check("R10 secure bank flag", 64'(sel_tgt), 1);
        ack = 1; @(negedge clk); ack = 0;
        check("R9 secure active", 64'(act_s), 64'h40);
        check("R7 shared copy now selected", 64'({sel_num, sel_secure}), 64'({5'd6, 1'b0}));

        // R7/R8: ordering
        do_reset(); exec_prio = 8;
        pend(17, 0, 0);
        check("R8 first pend pulses", 64'(preempt), 1);
        pend(16, 0, 0);
        check("R8 better pend pulses", 64'(preempt), 1);
        check("R7 best prio", 64'({sel_num, sel_prio}), 64'({5'd16, 4'd1}));
        pend(4, 0, 0);
        check("R8 worse pend no pulse", 64'(preempt), 0);
        @(negedge clk);
        check("R8 pulse one cycle", 64'(preempt), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule